// File: doc/BRIEF.md
# Event Counter Snapshot Unit

This block is a small group of event counters with a shadow copy for each counter. Each counter chooses one event source by a programmable ID. It can drop events whose accompanying stream ID fails a per-counter filter. When it wraps past its maximum value it raises a sticky overflow flag. The overflow flags, qualified by per-counter interrupt enables, drive a single interrupt line.

A snapshot copies every counter into its shadow register at the same clock edge. Two things start one. Software can write the capture control register, or a counter whose event-type register has its overflow-capture bit set can wrap. A sequencer with three states runs each capture:

- IDLE goes to COPY on any request, and the copy happens at that same edge.
- COPY goes to SETTLE unconditionally.
- SETTLE goes back to IDLE.

The pending bit reads 1 in COPY and SETTLE. Software polls that bit and reads the shadow registers only once it returns to 0.

Counters and shadows are 48 bits wide, so they sit on an 8-byte stride. Counters are in the main page, which has address bit 12 clear. Shadows are in the snapshot page, which has address bit 12 set. All other registers are 32 bits at 4-byte offsets in the main page. Reads are combinational while the read strobe is high, and writes take effect at the clock edge on which the write strobe is sampled.

Top module: `snap_pmu`

## Requirements
- R1: After reset, the following read 0 and the interrupt output is low: every counter, every shadow, the overflow flags, the interrupt enables, every event-type register and the pending bit.
- R2: The read-only register at 0xE00 returns 0x0040_2F03 for the default configuration. Bit 22 = capture supported, bits 13:8 = counter width minus one, bits 5:0 = counter count minus one.
- R3: Counter n sits at main-page offset 8n and is writable. In each cycle it adds one if the event source selected by bits 15:0 of event-type register n (at 0x400+4n) pulses and the filter passes. An ID of 4 or more counts nothing. A software write to the counter wins over a same-cycle increment.
- R4: Event-type bit 30 enables the stream filter, whose value sits at 0x600+4n. Bit 29 clear requires every stream-ID bit to equal the filter value. Bit 29 set ignores the lowest zero bit of the filter value and all bits below it, and compares only the bits above.
- R5: A counter at its maximum that increments becomes 0 and sets its overflow flag (bit n). The flags read at both 0xC80 and 0xCC0. Writing 1s to 0xCC0 sets flags, writing 1s to 0xC80 clears them, and a flag otherwise stays set.
- R6: The interrupt output is high exactly when some overflow flag has its enable bit set. Enables are set by writing 1s at 0xC40, cleared by writing 1s at 0xC60, and read at either address.
- R7: Writing a value with bit 0 set to 0xD88 copies every counter into its shadow (snapshot page offset 8n). The copied value is the one held before that cycle's increment.
- R8: Bit 0 of 0xD88 reads 1 for exactly the two cycles after an accepted capture request and then 0.
- R9: A capture request that arrives while a capture is pending is dropped and leaves every shadow unchanged.
- R10: When a counter with event-type bit 31 set wraps, all counters are copied into their shadows, holding their values from before that cycle's increments.
- R11: A software request and an overflow-triggered request in the same cycle produce one capture, with a single two-cycle pending window.
- R12: Shadows change only on a capture, and writes to the snapshot page are ignored.
- R13: A wrap of a counter whose event-type bit 31 is clear starts no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (13) | Byte address; bit 12 selects the snapshot page |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_wdata | input | DW (64) | Write data |
| bus_rdata | output | DW (64) | Read data |
| evt_in | input | NEVT (4) | One event pulse per source |
| txn_sid | input | SIDW (16) | Stream ID accompanying this cycle's events |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The counting path is tried with all 16 combinations of the four event lines, plus an out-of-range source ID. This separates the source selection of each counter from the others. The filter is swept over every stream ID of a 6-bit configuration, with the filter off, in exact mode and in pattern mode at three positions of the lowest zero bit. The resulting counts show whether the don't-care boundary sits exactly at that bit.

Capture is tried from software alone, from overflow alone, from both in one cycle, and again while pending. A concurrent increment shows whether pre-increment values are copied. A wrap of an unflagged counter shows that no capture starts.

// File: rtl/snap_pmu_pkg.sv
package snap_pmu_pkg;

    localparam logic [11:0] OFS_EVTYPE    = 12'h400;
    localparam logic [11:0] OFS_SIDFLT    = 12'h600;
    localparam logic [11:0] OFS_INTEN_SET = 12'hC40;
    localparam logic [11:0] OFS_INTEN_CLR = 12'hC60;
    localparam logic [11:0] OFS_OVF_CLR   = 12'hC80;
    localparam logic [11:0] OFS_OVF_SET   = 12'hCC0;
    localparam logic [11:0] OFS_CAPCTL    = 12'hD88;
    localparam logic [11:0] OFS_CONFIG    = 12'hE00;

    localparam int BIT_OVCAP  = 31;
    localparam int BIT_FLTEN  = 30;
    localparam int BIT_SPAN   = 29;
    localparam int BIT_CAPSUP = 22;

    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_COPY   = 2'd1,
        CAP_SETTLE = 2'd2
    } cap_state_e;

endpackage

// File: rtl/snap_sid_match.sv
module snap_sid_match #(
    parameter int SIDW = 16
) (
    input  logic [SIDW-1:0] sid,
    input  logic [SIDW-1:0] pattern,
    input  logic            span,
    output logic            hit
);
    localparam logic [SIDW-1:0] ONE = {{(SIDW-1){1'b0}}, 1'b1};

    logic [SIDW-1:0] dont_care;

    // Adding one flips the trailing ones and the lowest zero; the XOR marks them.
    always_comb begin
        dont_care = span ? (pattern ^ (pattern + ONE)) : '0;
        hit       = ((sid ^ pattern) & ~dont_care) == '0;
    end

endmodule

// File: rtl/snap_counter.sv
module snap_counter #(
    parameter int CW   = 48,
    parameter int NEVT = 4,
    parameter int SIDW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt_in,
    input  logic [SIDW-1:0] sid,
    input  logic [15:0]     evt_id,
    input  logic            flt_en,
    input  logic            span,
    input  logic [SIDW-1:0] pattern,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_val,
    output logic [CW-1:0]   count,
    output logic            wrap
);
    localparam int SELW = (NEVT > 1) ? $clog2(NEVT) : 1;

    logic sel_ok, src, sid_hit, inc;

    snap_sid_match #(.SIDW(SIDW)) u_match (
        .sid    (sid),
        .pattern(pattern),
        .span   (span),
        .hit    (sid_hit)
    );

    always_comb begin
        sel_ok = evt_id < 16'(NEVT);
        src    = sel_ok ? evt_in[evt_id[SELW-1:0]] : 1'b0;
        inc    = src && (!flt_en || sid_hit);
        wrap   = inc && !wr_en && (count == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (wr_en) count <= wr_val;
        else if (inc)   count <= count + 1'b1;
    end

    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_val)));

endmodule

// File: rtl/snap_capture_fsm.sv
module snap_capture_fsm
    import snap_pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic ovf_req,
    output logic take,
    output logic busy
);
    cap_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:   if (sw_req || ovf_req) state_d = CAP_COPY;
            CAP_COPY:   state_d = CAP_SETTLE;
            CAP_SETTLE: state_d = CAP_IDLE;
            default:    state_d = CAP_IDLE;
        endcase
    end

    always_comb begin
        take = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            CAP_IDLE:             take = sw_req || ovf_req;
            CAP_COPY, CAP_SETTLE: busy = 1'b1;
            default:              busy = 1'b0;
        endcase
    end

    assert_pending_two_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    assert_drop_when_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !take);

    assert_single_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && ovf_req && !busy) |=> busy ##1 busy);

endmodule

// File: rtl/snap_pmu.sv
module snap_pmu
    import snap_pmu_pkg::*;
#(
    parameter int NCNT = 4,
    parameter int CW   = 48,
    parameter int NEVT = 4,
    parameter int SIDW = 16,
    parameter int AW   = 13,
    parameter int DW   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NEVT-1:0] evt_in,
    input  logic [SIDW-1:0] txn_sid,
    output logic            ovf_irq
);
    localparam int STRIDE = (CW > 32) ? 8 : 4;
    localparam logic [31:0] CFG_VAL = (32'd1 << BIT_CAPSUP)
                                    | ((32'(CW - 1) & 32'h3F) << 8)
                                    | (32'(NCNT - 1) & 32'h3F);

    logic            page_snap, wr_main;
    logic [11:0]     ofs;
    logic [31:0]     evtype_q [NCNT];
    logic [SIDW-1:0] sidflt_q [NCNT];
    logic [CW-1:0]   snap_q   [NCNT];
    logic [CW-1:0]   cnt      [NCNT];
    logic [NCNT-1:0] cnt_wr, wrap, ovcap, ovs_q, inten_q, ovf_set, ovf_clr;
    logic            cap_take, cap_busy, sw_req, ovf_req;

    assign page_snap = bus_addr[AW-1];
    assign ofs       = bus_addr[11:0];
    assign wr_main   = bus_wr && !page_snap;

    generate
        if (CW < DW) begin : g_sink
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[DW-1:CW];
        end
    endgenerate

    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
        assign cnt_wr[n] = wr_main && (ofs == 12'(n * STRIDE));
        assign ovcap[n]  = evtype_q[n][BIT_OVCAP];

        snap_counter #(.CW(CW), .NEVT(NEVT), .SIDW(SIDW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_in (evt_in),
            .sid    (txn_sid),
            .evt_id (evtype_q[n][15:0]),
            .flt_en (evtype_q[n][BIT_FLTEN]),
            .span   (evtype_q[n][BIT_SPAN]),
            .pattern(sidflt_q[n]),
            .wr_en  (cnt_wr[n]),
            .wr_val (bus_wdata[CW-1:0]),
            .count  (cnt[n]),
            .wrap   (wrap[n])
        );

        assert_shadow_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_take |=> $stable(snap_q[n]));

        assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ovs_q[n] && !ovf_clr[n]) |=> ovs_q[n]);
    end

    assign sw_req  = wr_main && (ofs == OFS_CAPCTL) && bus_wdata[0];
    assign ovf_req = |(wrap & ovcap);
    assign ovf_set = wrap | ((wr_main && ofs == OFS_OVF_SET) ? bus_wdata[NCNT-1:0] : '0);
    assign ovf_clr = (wr_main && ofs == OFS_OVF_CLR) ? bus_wdata[NCNT-1:0] : '0;

    snap_capture_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_req (sw_req),
        .ovf_req(ovf_req),
        .take   (cap_take),
        .busy   (cap_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NCNT; n++) begin
                evtype_q[n] <= '0;
                sidflt_q[n] <= '0;
                snap_q[n]   <= '0;
            end
            ovs_q   <= '0;
            inten_q <= '0;
        end else begin
            for (int n = 0; n < NCNT; n++) begin
                if (wr_main && ofs == OFS_EVTYPE + 12'(4 * n)) evtype_q[n] <= bus_wdata[31:0];
                if (wr_main && ofs == OFS_SIDFLT + 12'(4 * n)) sidflt_q[n] <= bus_wdata[SIDW-1:0];
                if (cap_take) snap_q[n] <= cnt[n];
            end
            ovs_q <= (ovs_q & ~ovf_clr) | ovf_set;
            if (wr_main && ofs == OFS_INTEN_SET)      inten_q <= inten_q | bus_wdata[NCNT-1:0];
            else if (wr_main && ofs == OFS_INTEN_CLR) inten_q <= inten_q & ~bus_wdata[NCNT-1:0];
        end
    end

    assign ovf_irq = |(ovs_q & inten_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (page_snap) begin
                for (int n = 0; n < NCNT; n++)
                    if (ofs == 12'(n * STRIDE)) bus_rdata = DW'(snap_q[n]);
            end else begin
                for (int n = 0; n < NCNT; n++) begin
                    if (ofs == 12'(n * STRIDE))            bus_rdata = DW'(cnt[n]);
                    if (ofs == OFS_EVTYPE + 12'(4 * n))    bus_rdata = DW'(evtype_q[n]);
                    if (ofs == OFS_SIDFLT + 12'(4 * n))    bus_rdata = DW'(sidflt_q[n]);
                end
                case (ofs)
                    OFS_INTEN_SET, OFS_INTEN_CLR: bus_rdata = DW'(inten_q);
                    OFS_OVF_SET, OFS_OVF_CLR:     bus_rdata = DW'(ovs_q);
                    OFS_CAPCTL:                   bus_rdata = DW'(cap_busy);
                    OFS_CONFIG:                   bus_rdata = DW'(CFG_VAL);
                    default: ;
                endcase
            end
        end
    end

    assert_overflow_starts_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && !cap_busy) |=> cap_busy);

    assert_unflagged_wrap_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_busy && !sw_req && (wrap & ovcap) == '0) |=> !cap_busy);

endmodule

// File: tb/snap_pmu_test.sv
module snap_pmu_test;
    localparam int NCNT = 4, CW = 48, NEVT = 4, SIDW = 6, AW = 13, DW = 64;
    localparam logic [CW-1:0] CMAX = '1;

    logic            clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NEVT-1:0] evt_in = '0;
    logic [SIDW-1:0] txn_sid = '0;
    logic            ovf_irq;

    int errors = 0, checks = 0;

    snap_pmu #(.NCNT(NCNT), .CW(CW), .NEVT(NEVT), .SIDW(SIDW), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .txn_sid(txn_sid),
        .ovf_irq(ovf_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [AW-1:0] a, input logic [63:0] d,
                         input logic [NEVT-1:0] e, input logic [SIDW-1:0] s);
        bus_wr = w; bus_addr = a; bus_wdata = d; evt_in = e; txn_sid = s;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        drive(1'b1, a, d, '0, '0);
    endtask

    task automatic rdchk(input string req, input string what, input logic [AW-1:0] a, input logic [63:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, what, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    function automatic logic [AW-1:0] a_cnt(input int n);  return AW'(n * 8); endfunction
    function automatic logic [AW-1:0] a_evt(input int n);  return AW'(32'h400 + 4 * n); endfunction
    function automatic logic [AW-1:0] a_flt(input int n);  return AW'(32'h600 + 4 * n); endfunction
    function automatic logic [AW-1:0] a_snap(input int n); return AW'(32'h1000 + 8 * n); endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int n = 0; n < NCNT; n++) begin
            rdchk("R1", "counter", a_cnt(n), 64'd0);
            rdchk("R1", "shadow", a_snap(n), 64'd0);
            rdchk("R1", "evtype", a_evt(n), 64'd0);
        end
        rdchk("R1", "overflow flags", 13'hC80, 64'd0);
        rdchk("R1", "int enables", 13'hC40, 64'd0);
        rdchk("R1", "pending", 13'hD88, 64'd0);
        check("R1", "irq", 64'(ovf_irq), 64'd0);

        // R2: configuration word
        rdchk("R2", "config", 13'hE00, 64'h0040_2F03);

        // R3: every event pattern; counter 3 selects out-of-range source 5
        for (int n = 0; n < 3; n++) wr(a_evt(n), 64'(n));
        wr(a_evt(3), 64'd5);
        for (int p = 0; p < 16; p++) drive(1'b0, '0, '0, NEVT'(p), '0);
        for (int n = 0; n < NCNT; n++) begin
            int exp_c;
            exp_c = 0;
            for (int p = 0; p < 16; p++) if (n < 3 && ((p >> n) & 1) == 1) exp_c++;
            rdchk("R3", "event count", a_cnt(n), 64'(exp_c));
        end
        drive(1'b1, a_cnt(0), 64'h55, 4'b0001, '0);
        rdchk("R3", "write beats increment", a_cnt(0), 64'h55);

        // R4: exhaustive stream-ID sweep over filter modes
        for (int m = 0; m < 5; m++) begin
            int f, z, exp_c;
            logic en, span;
            case (m)
                0: begin f = 'h2A; en = 1'b0; span = 1'b0; end
                1: begin f = 'h2A; en = 1'b1; span = 1'b0; end
                2: begin f = 'h2B; en = 1'b1; span = 1'b1; end
                3: begin f = 'h17; en = 1'b1; span = 1'b1; end
                default: begin f = 'h3F; en = 1'b1; span = 1'b1; end
            endcase
            wr(a_flt(0), 64'(f));
            wr(a_evt(0), (64'(en) << 30) | (64'(span) << 29));
            wr(a_cnt(0), 64'd0);
            for (int s = 0; s < 64; s++) drive(1'b0, '0, '0, 4'b0001, SIDW'(s));
            z = SIDW;
            for (int b = SIDW - 1; b >= 0; b--) if (((f >> b) & 1) == 0) z = b;
            exp_c = 0;
            for (int s = 0; s < 64; s++) begin
                if (!en) exp_c++;
                else if (!span && s == f) exp_c++;
                else if (span && ((s >> (z + 1)) == (f >> (z + 1)))) exp_c++;
            end
            rdchk("R4", "filtered count", a_cnt(0), 64'(exp_c));
        end

        // R5 and R13: wrap without capture flag
        wr(a_cnt(2), 64'(CMAX - 1));
        drive(1'b0, '0, '0, 4'b0100, '0);
        drive(1'b0, '0, '0, 4'b0100, '0);
        rdchk("R5", "wrapped value", a_cnt(2), 64'd0);
        rdchk("R5", "flag via clear addr", 13'hC80, 64'h4);
        rdchk("R13", "no pending", 13'hD88, 64'd0);
        @(negedge clk);
        rdchk("R13", "shadow untouched", a_snap(2), 64'd0);
        wr(13'hCC0, 64'h1);
        rdchk("R5", "flag set via set addr", 13'hCC0, 64'h5);
        wr(13'hC80, 64'h5);
        rdchk("R5", "flags cleared", 13'hC80, 64'h0);

        // R6: interrupt qualification
        wr(13'hC40, 64'h1);
        check("R6", "irq enable without flag", 64'(ovf_irq), 64'd0);
        wr(13'hC60, 64'h1);
        wr(13'hCC0, 64'h2);
        check("R6", "irq flag without enable", 64'(ovf_irq), 64'd0);
        wr(13'hC40, 64'h2);
        check("R6", "irq flag and enable", 64'(ovf_irq), 64'd1);
        rdchk("R6", "enables", 13'hC60, 64'h2);
        wr(13'hC60, 64'h2);
        check("R6", "irq after disable", 64'(ovf_irq), 64'd0);
        wr(13'hC80, 64'h2);

        // R7 and R8: software capture with concurrent increments
        wr(a_evt(0), 64'd0);
        for (int n = 0; n < NCNT; n++) wr(a_cnt(n), 64'(100 * (n + 1)));
        drive(1'b1, 13'hD88, 64'h1, 4'b0011, '0);
        rdchk("R8", "pending cycle 1", 13'hD88, 64'd1);
        @(negedge clk);
        rdchk("R8", "pending cycle 2", 13'hD88, 64'd1);
        @(negedge clk);
        rdchk("R8", "pending cleared", 13'hD88, 64'd0);
        for (int n = 0; n < NCNT; n++) rdchk("R7", "shadow", a_snap(n), 64'(100 * (n + 1)));
        rdchk("R7", "counter 0 moved on", a_cnt(0), 64'd101);

        // R9: second request while pending
        drive(1'b1, 13'hD88, 64'h1, 4'b0000, '0);
        drive(1'b1, 13'hD88, 64'h1, 4'b0001, '0);
        rdchk("R8", "pending in settle", 13'hD88, 64'd1);
        @(negedge clk);
        rdchk("R9", "pending done", 13'hD88, 64'd0);
        rdchk("R9", "shadow kept first copy", a_snap(0), 64'd101);
        rdchk("R9", "counter incremented", a_cnt(0), 64'd102);

        // R10: overflow-triggered capture
        wr(a_evt(1), 64'h8000_0001);
        wr(a_cnt(1), 64'(CMAX));
        wr(a_cnt(0), 64'd10);
        drive(1'b0, '0, '0, 4'b0011, '0);
        rdchk("R10", "pending after wrap", 13'hD88, 64'd1);
        repeat (2) @(negedge clk);
        rdchk("R10", "shadow of wrapping counter", a_snap(1), 64'(CMAX));
        rdchk("R10", "shadow pre-increment", a_snap(0), 64'd10);
        rdchk("R10", "counter wrapped", a_cnt(1), 64'd0);
        rdchk("R10", "counter 0 after", a_cnt(0), 64'd11);

        // R11: simultaneous software and overflow request
        wr(a_cnt(1), 64'(CMAX));
        drive(1'b1, 13'hD88, 64'h1, 4'b0010, '0);
        rdchk("R11", "pending 1", 13'hD88, 64'd1);
        @(negedge clk);
        rdchk("R11", "pending 2", 13'hD88, 64'd1);
        @(negedge clk);
        rdchk("R11", "idle", 13'hD88, 64'd0);
        @(negedge clk);
        rdchk("R11", "no second capture", 13'hD88, 64'd0);
        rdchk("R11", "shadow value", a_snap(1), 64'(CMAX));

        // R12: snapshot page is read-only
        wr(a_snap(0), 64'hDEAD);
        rdchk("R12", "shadow unaffected by write", a_snap(0), 64'd11);
        drive(1'b0, '0, '0, 4'b0001, '0);
        rdchk("R12", "shadow stable while counting", a_snap(0), 64'd11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule